// File: doc/BRIEF.md
# TDM Channel Blocking Signal Generator

This block produces a per-timeslot blocking strobe for the transmit side of a TDM backplane. It runs from the backplane bit clock and tracks the bit position inside each frame. A frame sync pulse re-aligns the position to zero. If no sync arrives, the position wraps by itself at the frame length. A 32-bit channel mask, loaded as four bytes through a small write port, decides for each channel time whether the strobe is high or low. Downstream logic uses the strobe to gate or substitute data in the selected timeslots.

Two backplane formats are supported. The 32-channel format has 256 bit times per frame, with channel n on positions 8(n-1) to 8(n-1)+7. The 24-channel format has 193 bit times per frame: position 0 is the framing bit, and channel n occupies positions 8(n-1)+1 to 8(n-1)+8. In the 24-channel format, bit 0 of the fourth mask byte stops acting as a channel bit. It instead decides whether the strobe is raised for the single framing-bit position.

Mask writes go into a shadow copy. The working copy takes them over only at a channel boundary, so the strobe never changes in the middle of a channel time.

Top module: `tdm_chblk_gen`

## Requirements
- R1: After reset, `blk_out` is 0 and all 32 mask bits are 0, so the strobe stays low for a whole frame until the mask is written.
- R2: In the 32-channel format (`fmt_t1`=0), `blk_out` equals mask bit n-1 at all 8 bit positions of channel n. Mask byte address 0 holds channels 1-8, address 1 holds 9-16, address 2 holds 17-24 and address 3 holds 25-32, each with its least significant bit as the lowest channel.
- R3: Without a sync, the bit position wraps to 0 after position 255 in the 32-channel format and after position 192 in the 24-channel format.
- R4: In the 24-channel format (`fmt_t1`=1), `blk_out` at position 0 (the framing bit) equals bit 0 of mask byte address 3.
- R5: In the 24-channel format, `blk_out` at positions 8(n-1)+1 to 8(n-1)+8 equals mask bit n-1, for channels 1 to 24 (mask byte addresses 0 to 2).
- R6: In the 24-channel format, bits 1 to 7 of mask byte address 3 have no effect on `blk_out`.
- R7: When `fsync` is high at a rising clock edge, that edge starts bit position 0, even in the middle of a frame.
- R8: A mask write takes effect from the first channel boundary that falls after the edge that performs the write. If the write edge is itself a boundary, the old value still applies to that channel. `blk_out` never changes between two boundaries.
- R9: `blk_out` is registered. The value for a bit position appears just after the clock edge that starts that position and holds until the next edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Backplane bit clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| fsync | input | 1 | Frame sync; high at an edge makes that edge start position 0 |
| fmt_t1 | input | 1 | 0 = 32-channel 256-bit frame, 1 = 24-channel 193-bit frame with framing bit |
| wr_en | input | 1 | Mask byte write strobe |
| wr_addr | input | 2 | Mask byte select (0 = channels 1-8 ... 3 = channels 25-32 / framing-bit flag) |
| wr_data | input | 8 | Mask byte value |
| blk_out | output | 1 | Channel blocking strobe |

## Verification
A mask write and a channel boundary can land on the same clock edge. In that case the shadow byte changes while the working copy is being reloaded from it. The bench provokes this by driving a write on the very edge that starts a channel, and it expects the old mask bit for that channel and the new one only from the following channel. A frame sync can also arrive in the middle of a frame, where it both restarts the count and forces a boundary reload. The bench fires it part-way through a channel and judges every later position against a model that was restarted at zero.

// File: rtl/tdm_chblk_pkg.sv
package tdm_chblk_pkg;

  // Number of bit positions in one frame for the selected format.
  function automatic int frame_len(input logic t1, input int slot_bits,
                                   input int e1_ch, input int t1_ch);
    return t1 ? (t1_ch * slot_bits + 1) : (e1_ch * slot_bits);
  endfunction

  // Zero-based channel index that covers bit position pos.
  function automatic int slot_of(input logic t1, input int pos, input int slot_bits);
    int base;
    base = t1 ? pos - 1 : pos;
    if (base < 0) base = 0;
    return base / slot_bits;
  endfunction

  // True when pos is the first bit of a channel (or the framing bit).
  function automatic logic slot_first(input logic t1, input int pos, input int slot_bits);
    if (t1) return (pos == 0) || (((pos - 1) % slot_bits) == 0);
    return (pos % slot_bits) == 0;
  endfunction

endpackage

// File: rtl/chblk_pos_counter.sv
module chblk_pos_counter #(
  parameter int SLOT_BITS = 8,
  parameter int E1_CH     = 32,
  parameter int T1_CH     = 24,
  parameter int POS_W     = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fsync,
  input  logic             fmt_t1,
  output logic [POS_W-1:0] pos_q,
  output logic [POS_W-1:0] pos_nxt,
  output logic             frame_end,
  output logic             fmt_flip
);
  import tdm_chblk_pkg::*;

  logic fmt_q;
  int   cur_len;

  always_comb begin
    cur_len   = frame_len(fmt_t1, SLOT_BITS, E1_CH, T1_CH);
    frame_end = int'(pos_q) >= (cur_len - 1);
    pos_nxt   = (fsync || frame_end) ? '0 : pos_q + POS_W'(1);
    fmt_flip  = fmt_t1 != fmt_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pos_q <= '0;
      fmt_q <= 1'b0;
    end else begin
      pos_q <= pos_nxt;
      fmt_q <= fmt_t1;
    end
  end

  AST_POS_BELOW_LEN: assert property (@(posedge clk) disable iff (!rst_n)
    int'(pos_q) < frame_len(fmt_q, SLOT_BITS, E1_CH, T1_CH)); // R3

  AST_WRAP_TO_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    frame_end |=> (pos_q == '0)); // R3

  AST_SYNC_TO_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    fsync |=> (pos_q == '0)); // R7

endmodule

// File: rtl/chblk_mask_regs.sv
module chblk_mask_regs #(
  parameter int NUM_REGS = 4,
  parameter int REG_W    = 8,
  parameter int AW       = 2,
  parameter int MW       = NUM_REGS * REG_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [REG_W-1:0] wr_data,
  input  logic          load,
  output logic [MW-1:0] shadow,
  output logic [MW-1:0] active
);

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_byte
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) shadow[g*REG_W +: REG_W] <= '0;
      else if (wr_en && (int'(wr_addr) == g)) shadow[g*REG_W +: REG_W] <= wr_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    active <= '0;
    else if (load) active <= shadow;
  end

  AST_ACTIVE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> $stable(active)); // R8

endmodule

// File: rtl/chblk_decode.sv
module chblk_decode #(
  parameter int SLOT_BITS = 8,
  parameter int E1_CH     = 32,
  parameter int T1_CH     = 24,
  parameter int POS_W     = 8,
  parameter int MW        = 32,
  parameter int IDX_W     = 5
) (
  input  logic [POS_W-1:0] pos,
  input  logic             fmt_t1,
  input  logic [MW-1:0]    mask,
  output logic             bit_val,
  output logic             slot_start,
  output logic             fbit
);
  import tdm_chblk_pkg::*;

  logic [IDX_W-1:0] idx;
  int               p;

  always_comb begin
    p          = int'(pos);
    fbit       = fmt_t1 && (p == 0);
    slot_start = slot_first(fmt_t1, p, SLOT_BITS);
    idx        = IDX_W'(slot_of(fmt_t1, p, SLOT_BITS));
    bit_val    = fbit ? mask[T1_CH] : mask[idx];
  end

endmodule

// File: rtl/tdm_chblk_gen.sv
module tdm_chblk_gen #(
  parameter int SLOT_BITS = 8,
  parameter int E1_CH     = 32,
  parameter int T1_CH     = 24,
  parameter int NUM_REGS  = 4,
  parameter int REG_W     = 8,
  localparam int AW       = $clog2(NUM_REGS),
  localparam int MW       = NUM_REGS * REG_W,
  localparam int POS_W    = $clog2(SLOT_BITS * E1_CH),
  localparam int IDX_W    = $clog2(E1_CH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fsync,
  input  logic             fmt_t1,
  input  logic             wr_en,
  input  logic [AW-1:0]    wr_addr,
  input  logic [REG_W-1:0] wr_data,
  output logic             blk_out
);

  logic [POS_W-1:0] pos_q, pos_nxt;
  logic             frame_end, fmt_flip;
  logic [MW-1:0]    shadow, active, mask_sel;
  logic             bit_val, slot_start, fbit, load;

  chblk_pos_counter #(
    .SLOT_BITS(SLOT_BITS), .E1_CH(E1_CH), .T1_CH(T1_CH), .POS_W(POS_W)
  ) u_cnt (
    .clk(clk), .rst_n(rst_n), .fsync(fsync), .fmt_t1(fmt_t1),
    .pos_q(pos_q), .pos_nxt(pos_nxt), .frame_end(frame_end), .fmt_flip(fmt_flip)
  );

  // A new channel (or a format change) picks up the shadow mask at once.
  assign load     = slot_start || fmt_flip;
  assign mask_sel = load ? shadow : active;

  chblk_mask_regs #(
    .NUM_REGS(NUM_REGS), .REG_W(REG_W), .AW(AW), .MW(MW)
  ) u_mask (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .load(load), .shadow(shadow), .active(active)
  );

  chblk_decode #(
    .SLOT_BITS(SLOT_BITS), .E1_CH(E1_CH), .T1_CH(T1_CH),
    .POS_W(POS_W), .MW(MW), .IDX_W(IDX_W)
  ) u_dec (
    .pos(pos_nxt), .fmt_t1(fmt_t1), .mask(mask_sel),
    .bit_val(bit_val), .slot_start(slot_start), .fbit(fbit)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) blk_out <= 1'b0;
    else        blk_out <= bit_val;
  end

  AST_HOLD_IN_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> $stable(blk_out)); // R8

  AST_FBIT_IS_START: assert property (@(posedge clk) disable iff (!rst_n)
    fbit |-> (slot_start && fmt_t1)); // R4

endmodule

// File: tb/tdm_chblk_gen_bench.sv
`timescale 1ns/1ps
module tdm_chblk_gen_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       fsync = 1'b0;
  logic       fmt_t1 = 1'b0;
  logic       wr_en = 1'b0;
  logic [1:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic       blk_out;

  int  n_chk = 0;
  int  n_bad = 0;
  bit  finished = 1'b0;

  // bench model state
  bit          mode_m = 1'b0;
  int          mp = 0;
  logic [31:0] shadow_m = '0;
  logic [31:0] act_m = '0;
  logic        exp_prev = 1'b0;

  always #2.5 clk = ~clk;

  tdm_chblk_gen u_tdm_chblk_gen (
    .clk(clk), .rst_n(rst_n), .fsync(fsync), .fmt_t1(fmt_t1),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .blk_out(blk_out)
  );

  function automatic int flen(bit m);
    return m ? 193 : 256;
  endfunction

  function automatic bit is_bnd(bit m, int p);
    if (m) return (p == 0) || ((p % 8) == 1);
    return (p & 7) == 0;
  endfunction

  function automatic logic exp_of(bit m, int p, logic [31:0] msk);
    if (!m)     return msk[p >> 3];
    if (p == 0) return msk[24];
    return msk[(p - 1) >> 3];
  endfunction

  task automatic check(input logic act, input logic exp, input string tag);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: blk_out=%0b expected=%0b pos=%0d mode=%0d", tag, act, exp, mp, mode_m);
    end
  endtask

  // Called at a falling edge: drives one rising edge and checks around it.
  task automatic step(input bit sync, input bit we, input logic [1:0] a,
                      input logic [7:0] d, input string tag);
    logic e;
    fsync   = sync;
    wr_en   = we;
    wr_addr = a;
    wr_data = d;
    fmt_t1  = mode_m;
    check(blk_out, exp_prev, "R9");
    if (sync || (mp + 1 >= flen(mode_m))) mp = 0;
    else mp = mp + 1;
    if (is_bnd(mode_m, mp)) act_m = shadow_m;
    if (we) shadow_m[int'(a)*8 +: 8] = d;
    e = exp_of(mode_m, mp, act_m);
    @(posedge clk);
    #1;
    check(blk_out, e, tag);
    exp_prev = e;
    @(negedge clk);
    fsync = 1'b0;
    wr_en = 1'b0;
  endtask

  task automatic set_mask(input logic [31:0] m, input string tag);
    for (int i = 0; i < 4; i++) step(1'b0, 1'b1, 2'(i), m[i*8 +: 8], tag);
  endtask

  task automatic run(input bit sync_first, input int n, input string tag);
    for (int i = 0; i < n; i++) step(sync_first && (i == 0), 1'b0, 2'd0, 8'd0, tag);
  endtask

  initial begin
    #(5.0 * 200000);
    if (!finished) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: run did not complete");
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check(blk_out, 1'b0, "R1");
    rst_n = 1'b1;
    @(negedge clk);
    check(blk_out, 1'b0, "R1");
    // R1: unwritten mask keeps the strobe low for a full frame
    run(1'b1, 256, "R1");

    // R2: walk a single set channel across all 32 channels
    mode_m = 1'b0;
    for (int ch = 0; ch < 32; ch++) begin
      set_mask(32'h1 << ch, "R2");
      run(1'b1, 256, "R2");
    end
    // R2/R3: dense patterns, run past the frame end without sync
    set_mask(32'hA5C3_0F96, "R2");
    run(1'b1, 300, "R3");
    set_mask(32'h5A3C_F069, "R2");
    run(1'b1, 520, "R3");

    // R5: 24-channel format, walk channels 1..24
    mode_m = 1'b1;
    for (int ch = 0; ch < 24; ch++) begin
      set_mask(32'h1 << ch, "R5");
      run(1'b1, 193, "R5");
    end
    // R4: framing-bit flag alone, then cleared; also wrap at 193 (R3)
    set_mask(32'h0100_0000, "R4");
    run(1'b1, 400, "R4");
    set_mask(32'h0000_0000, "R4");
    run(1'b1, 200, "R4");
    // R6: upper flag bits set, framing flag clear, channels all set
    set_mask(32'hFE00_0000, "R6");
    run(1'b1, 200, "R6");
    set_mask(32'hFEFF_FFFF, "R6");
    run(1'b1, 200, "R6");
    set_mask(32'hFF00_00FF, "R6");
    run(1'b1, 200, "R6");

    // R7: sync mid-frame in both formats
    set_mask(32'h0155_AA0F, "R7");
    run(1'b1, 100, "R7");
    run(1'b1, 230, "R7");
    mode_m = 1'b0;
    set_mask(32'h9C35_AA0F, "R7");
    run(1'b1, 61, "R7");
    run(1'b1, 270, "R7");

    // R8: write in the middle of a channel, then on a boundary edge
    set_mask(32'h0, "R8");
    run(1'b1, 44, "R8");                  // model position now 43
    step(1'b0, 1'b1, 2'd1, 8'hFF, "R8");  // edge starts 44; load at 48
    run(1'b0, 300, "R8");
    run(1'b1, 48, "R8");                  // model position now 47
    step(1'b0, 1'b1, 2'd0, 8'hFF, "R8");  // edge starts 48 (boundary)
    run(1'b0, 300, "R8");
    mode_m = 1'b1;
    run(1'b1, 9, "R8");                   // position 8, next edge starts channel 2
    step(1'b0, 1'b1, 2'd3, 8'h01, "R8");  // flag write on a boundary edge
    run(1'b0, 400, "R8");

    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule